// File: doc/BRIEF.md
# Unlock-Gated Address-Bus Command Decoder

This block sits beside a flash read bus and watches every read access. Each access address is treated as a packed pair: the upper eight bits form a command address and the lower sixteen bits form a data word. Ordinary reads pass the block without effect. A fixed five-access key sequence arms the decoder. The access that follows the key is taken as a single command and loads one of several internal control registers. The decoder then drops back to idle.

The loaded state consists of five 16-bit words, three option flags and an ID-mode flag. The words are control word 0, control word 1, an I/O status word, a flash bank and a save-RAM bank. Three convenience outputs are derived from the control words: the flash write enable, the game/menu flash select and the extended address range enable. A host steers the block by issuing reads at chosen addresses, so no write path is needed.

Top module: `ucd_unlock_decoder`

## Requirements
- R1: After reset, every register output, option flag, ID-mode flag, derived output and the armed indication is zero.
- R2: Each access with `bus_valid` high splits into a command address, `bus_addr[23:16]`, and a data word, `bus_addr[15:0]`.
- R3: The key is five accesses in this order, given as (address, data): (FF, D200), (00, 1500), (01, D200), (02, 1500), (FE, 1500). Once the key completes, `armed_o` is high. The next valid access is decoded as a command, and its effect is visible on the outputs in the cycle after the edge that samples it.
- R4: A valid access that does not match the expected key step, and does not equal the first key step, returns the matcher to idle. A later command-like access is then ignored.
- R5: A mismatching valid access that equals the first key step (FF, D200) leaves the matcher waiting for the second step.
- R6: Exactly one access is taken as a command per completed key. The matcher then returns to idle, and further accesses change no register.
- R7: Command address 0x37 loads control word 0. 0xEE loads control word 1. 0xDA loads the I/O status word. 0xC4 loads the flash bank. 0xE0 loads the save-RAM bank. In each case the value loaded is the full data word.
- R8: A command with any other address changes no register, and the matcher still returns to idle.
- R9: Command 0x90 with data 0x3500 sets ID mode, and with data 0x4900 clears it. Any other data leaves ID mode unchanged.
- R10: Command 0xE2 sets or clears one option flag, depending on its data. 0x1500 sets the PSRAM write enable and 0xD200 clears it. 0xDD00 sets wide save-RAM write and 0x3900 clears it. 0x7E00 sets wide save-RAM read and 0x9400 clears it. Any other data changes no flag.
- R11: `flash_we_o` follows bit 13 of control word 0. `game_flash_o` follows bit 9 of control word 0. `ext_range_o` is high exactly when control word 1 equals 0x0630.
- R12: Cycles with `bus_valid` low do not advance, break or consume the key or the armed state, whatever `bus_addr` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | One read access is present this cycle |
| bus_addr | input | 24 | Access address: command address in the high byte, data word in the low 16 bits |
| ctrl0_o | output | 16 | Control word 0 |
| ctrl1_o | output | 16 | Control word 1 |
| iostat_o | output | 16 | I/O status word |
| fbank_o | output | 16 | Flash bank |
| sbank_o | output | 16 | Save-RAM bank |
| psram_we_o | output | 1 | PSRAM write enable flag |
| wide_wr_o | output | 1 | Wide save-RAM write flag |
| wide_rd_o | output | 1 | Wide save-RAM read flag |
| id_mode_o | output | 1 | ID mode flag |
| flash_we_o | output | 1 | Flash write enable (control word 0 bit 13) |
| game_flash_o | output | 1 | Game flash selected (control word 0 bit 9) |
| ext_range_o | output | 1 | Extended flash address range enabled |
| armed_o | output | 1 | Key complete; the next access is a command |

## Verification
The bench builds the block with its default 8-bit command field, 16-bit data field and five-step key. These defaults put the whole key and command map within reach of directed sequences. They also allow a random stretch whose accesses are drawn only from key steps and command encodings, so partial keys, restarts on the first step and idle gaps interleave often. A behavioural model tracks the key position as an integer and compares every output on every clock.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam int unsigned CMD_W     = 8;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned BUS_W     = CMD_W + DATA_W;
  localparam int unsigned KEY_LEN   = 5;
  localparam int unsigned NUM_WORDS = 5;

  typedef logic [CMD_W-1:0]  cmd_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef struct packed {
    cmd_t  addr;
    word_t data;
  } access_t;

  typedef struct packed {
    logic psram_we;
    logic wide_wr;
    logic wide_rd;
  } opt_flags_t;

  // word slot indices
  localparam int unsigned W_CTRL0  = 0;
  localparam int unsigned W_CTRL1  = 1;
  localparam int unsigned W_IOSTAT = 2;
  localparam int unsigned W_FBANK  = 3;
  localparam int unsigned W_SBANK  = 4;

  localparam cmd_t OP_OPTS   = 8'hE2;
  localparam cmd_t OP_IDMODE = 8'h90;

  localparam word_t ID_ENTER      = 16'h3500;
  localparam word_t ID_LEAVE      = 16'h4900;
  localparam word_t OPT_PSRAM_SET = 16'h1500;
  localparam word_t OPT_PSRAM_CLR = 16'hD200;
  localparam word_t OPT_WWR_SET   = 16'hDD00;
  localparam word_t OPT_WWR_CLR   = 16'h3900;
  localparam word_t OPT_WRD_SET   = 16'h7E00;
  localparam word_t OPT_WRD_CLR   = 16'h9400;
  localparam word_t EXT_RANGE_VAL = 16'h0630;

  localparam int unsigned CTRL0_FLASH_WE_BIT = 13;
  localparam int unsigned CTRL0_GAME_BIT     = 9;

  function automatic access_t split_bus(input logic [BUS_W-1:0] bus);
    access_t a;
    a.addr = bus[BUS_W-1:DATA_W];
    a.data = bus[DATA_W-1:0];
    return a;
  endfunction

  function automatic access_t key_step(input int unsigned idx);
    access_t k;
    case (idx)
      0:       k = '{addr: 8'hFF, data: 16'hD200};
      1:       k = '{addr: 8'h00, data: 16'h1500};
      2:       k = '{addr: 8'h01, data: 16'hD200};
      3:       k = '{addr: 8'h02, data: 16'h1500};
      4:       k = '{addr: 8'hFE, data: 16'h1500};
      default: k = '0;
    endcase
    return k;
  endfunction

  function automatic cmd_t word_opcode(input int unsigned idx);
    cmd_t c;
    case (idx)
      W_CTRL0:  c = 8'h37;
      W_CTRL1:  c = 8'hEE;
      W_IOSTAT: c = 8'hDA;
      W_FBANK:  c = 8'hC4;
      W_SBANK:  c = 8'hE0;
      default:  c = '0;
    endcase
    return c;
  endfunction

  function automatic opt_flags_t opt_apply(input opt_flags_t cur, input word_t d);
    opt_flags_t n;
    n = cur;
    case (d)
      OPT_PSRAM_SET: n.psram_we = 1'b1;
      OPT_PSRAM_CLR: n.psram_we = 1'b0;
      OPT_WWR_SET:   n.wide_wr  = 1'b1;
      OPT_WWR_CLR:   n.wide_wr  = 1'b0;
      OPT_WRD_SET:   n.wide_rd  = 1'b1;
      OPT_WRD_CLR:   n.wide_rd  = 1'b0;
      default:       n = cur;
    endcase
    return n;
  endfunction

  function automatic logic id_apply(input logic cur, input word_t d);
    if (d == ID_ENTER) return 1'b1;
    if (d == ID_LEAVE) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/ucd_key_matcher.sv
module ucd_key_matcher
  import ucd_pkg::*;
#(
  parameter int unsigned KEY_LEN = ucd_pkg::KEY_LEN
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acc_valid,
  input  access_t acc,
  output logic    cmd_fire,
  output logic    armed
);

  localparam int unsigned STEP_W = $clog2(KEY_LEN + 1);

  logic [STEP_W-1:0]  step_q, step_d;
  logic [KEY_LEN-1:0] hit;
  logic               exp_hit;
  logic               restart_hit;

  for (genvar g = 0; g < KEY_LEN; g++) begin : g_hit
    assign hit[g] = acc_valid && (acc == key_step(g));
  end

  assign armed       = (step_q == STEP_W'(KEY_LEN));
  assign restart_hit = hit[0];
  assign cmd_fire    = acc_valid && armed;

  always_comb begin
    exp_hit = 1'b0;
    for (int i = 0; i < KEY_LEN; i++) begin
      if (step_q == STEP_W'(i)) exp_hit = hit[i];
    end
  end

  always_comb begin
    step_d = step_q;
    if (acc_valid) begin
      if (armed)            step_d = '0;
      else if (exp_hit)     step_d = step_q + STEP_W'(1);
      else if (restart_hit) step_d = STEP_W'(1);
      else                  step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !armed && exp_hit) |=> (step_q == $past(step_q) + STEP_W'(1)));

  p_break_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !armed && !exp_hit && !restart_hit) |=> (step_q == '0));

  p_restart_step2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !armed && !exp_hit && restart_hit) |=> (step_q == STEP_W'(1)));

  p_single_command_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (!armed && step_q == '0));

  p_hold_when_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(step_q));

endmodule

// File: rtl/ucd_cmd_decode.sv
module ucd_cmd_decode
  import ucd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_fire,
  input  access_t              acc,
  output logic [NUM_WORDS-1:0] word_wr,
  output logic                 opt_wr,
  output logic                 id_wr,
  output logic                 unknown
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    assign word_wr[g] = cmd_fire && (acc.addr == word_opcode(g));
  end

  assign opt_wr  = cmd_fire && (acc.addr == OP_OPTS);
  assign id_wr   = cmd_fire && (acc.addr == OP_IDMODE);
  assign unknown = cmd_fire && !(|word_wr) && !opt_wr && !id_wr;

  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_wr, opt_wr, id_wr, unknown}));

  p_fire_has_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |-> ($countones({word_wr, opt_wr, id_wr, unknown}) == 1));

  p_no_target_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |-> ({word_wr, opt_wr, id_wr, unknown} == '0));

endmodule

// File: rtl/ucd_ctrl_regs.sv
module ucd_ctrl_regs
  import ucd_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_WORDS-1:0]              word_wr,
  input  logic                              opt_wr,
  input  logic                              id_wr,
  input  logic                              unknown,
  input  word_t                             data,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words,
  output opt_flags_t                        opts,
  output logic                              id_mode
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          words[g] <= '0;
      else if (word_wr[g]) words[g] <= data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opts    <= '0;
      id_mode <= 1'b0;
    end else begin
      if (opt_wr) opts    <= opt_apply(opts, data);
      if (id_wr)  id_mode <= id_apply(id_mode, data);
    end
  end

  p_words_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|word_wr) |=> $stable(words));

  p_unknown_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unknown |=> ($stable(words) && $stable(opts) && $stable(id_mode)));

  p_id_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr && data == ID_ENTER) |=> id_mode);

  p_id_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr && data == ID_LEAVE) |=> !id_mode);

  p_id_other_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (id_wr && data != ID_ENTER && data != ID_LEAVE) |=> $stable(id_mode));

  p_opts_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_wr |=> $stable(opts));

  p_psram_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_wr && data == OPT_PSRAM_SET) |=> opts.psram_we);

  p_wide_rd_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_wr && data == OPT_WRD_CLR) |=> !opts.wide_rd);

endmodule

// File: rtl/ucd_unlock_decoder.sv
module ucd_unlock_decoder
  import ucd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  input  logic [BUS_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]   ctrl0_o,
  output logic [DATA_W-1:0]   ctrl1_o,
  output logic [DATA_W-1:0]   iostat_o,
  output logic [DATA_W-1:0]   fbank_o,
  output logic [DATA_W-1:0]   sbank_o,
  output logic                psram_we_o,
  output logic                wide_wr_o,
  output logic                wide_rd_o,
  output logic                id_mode_o,
  output logic                flash_we_o,
  output logic                game_flash_o,
  output logic                ext_range_o,
  output logic                armed_o
);

  access_t                          acc;
  logic                             cmd_fire;
  logic                             armed;
  logic [NUM_WORDS-1:0]             word_wr;
  logic                             opt_wr;
  logic                             id_wr;
  logic                             unknown;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  opt_flags_t                       opts;
  logic                             id_mode;

  assign acc = split_bus(bus_addr);

  ucd_key_matcher #(.KEY_LEN(KEY_LEN)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (bus_valid),
    .acc       (acc),
    .cmd_fire  (cmd_fire),
    .armed     (armed)
  );

  ucd_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_fire (cmd_fire),
    .acc      (acc),
    .word_wr  (word_wr),
    .opt_wr   (opt_wr),
    .id_wr    (id_wr),
    .unknown  (unknown)
  );

  ucd_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_wr (word_wr),
    .opt_wr  (opt_wr),
    .id_wr   (id_wr),
    .unknown (unknown),
    .data    (acc.data),
    .words   (words),
    .opts    (opts),
    .id_mode (id_mode)
  );

  assign ctrl0_o      = words[W_CTRL0];
  assign ctrl1_o      = words[W_CTRL1];
  assign iostat_o     = words[W_IOSTAT];
  assign fbank_o      = words[W_FBANK];
  assign sbank_o      = words[W_SBANK];
  assign psram_we_o   = opts.psram_we;
  assign wide_wr_o    = opts.wide_wr;
  assign wide_rd_o    = opts.wide_rd;
  assign id_mode_o    = id_mode;
  assign flash_we_o   = ctrl0_o[CTRL0_FLASH_WE_BIT];
  assign game_flash_o = ctrl0_o[CTRL0_GAME_BIT];
  assign ext_range_o  = (ctrl1_o == EXT_RANGE_VAL);
  assign armed_o      = armed;

  p_ext_range_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr[W_CTRL1] && acc.data == EXT_RANGE_VAL) |=> ext_range_o);

  p_ctrl0_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr[W_CTRL0] |=> (ctrl0_o == $past(acc.data)));

  p_fire_only_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_o) |-> !$past(armed_o));

endmodule

// File: tb/ucd_unlock_decoder_test.sv
`timescale 1ns/1ps
module ucd_unlock_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] ctrl0_o, ctrl1_o, iostat_o, fbank_o, sbank_o;
  logic        psram_we_o, wide_wr_o, wide_rd_o, id_mode_o;
  logic        flash_we_o, game_flash_o, ext_range_o, armed_o;

  always #2 clk = ~clk;

  ucd_unlock_decoder uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .iostat_o(iostat_o),
    .fbank_o(fbank_o), .sbank_o(sbank_o), .psram_we_o(psram_we_o),
    .wide_wr_o(wide_wr_o), .wide_rd_o(wide_rd_o), .id_mode_o(id_mode_o),
    .flash_we_o(flash_we_o), .game_flash_o(game_flash_o),
    .ext_range_o(ext_range_o), .armed_o(armed_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [23:0] key [5] = '{24'hFFD200, 24'h001500, 24'h01D200, 24'h021500, 24'hFE1500};

  // behavioural reference state
  int          m_step = 0;
  logic [15:0] m_c0 = 0, m_c1 = 0, m_io = 0, m_fb = 0, m_sb = 0;
  bit          m_pw = 0, m_ww = 0, m_wr = 0, m_id = 0;
  string       last_tag = "R1";

  task automatic chk(input string tag, input string what, input int act, input int exp, inout bit bad);
    if (act != exp) begin
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      bad = 1'b1;
    end
  endtask

  task automatic compare(input string tag);
    bit bad = 1'b0;
    vectors++;
    chk(tag, "ctrl0", ctrl0_o, m_c0, bad);
    chk(tag, "ctrl1", ctrl1_o, m_c1, bad);
    chk(tag, "iostat", iostat_o, m_io, bad);
    chk(tag, "fbank", fbank_o, m_fb, bad);
    chk(tag, "sbank", sbank_o, m_sb, bad);
    chk(tag, "psram_we", psram_we_o, m_pw, bad);
    chk(tag, "wide_wr", wide_wr_o, m_ww, bad);
    chk(tag, "wide_rd", wide_rd_o, m_wr, bad);
    chk(tag, "id_mode", id_mode_o, m_id, bad);
    // R11: derived outputs
    chk(tag, "flash_we", flash_we_o, m_c0[13], bad);
    chk(tag, "game_flash", game_flash_o, m_c0[9], bad);
    chk(tag, "ext_range", ext_range_o, (m_c1 == 16'h0630), bad);
    chk(tag, "armed", armed_o, (m_step == 5), bad);
    if (bad) miscompares++;
  endtask

  function automatic void model(input logic v, input logic [23:0] a);
    logic [7:0]  op = a[23:16];
    logic [15:0] d  = a[15:0];
    if (!v) return;
    if (m_step == 5) begin
      case (op)
        8'h37: m_c0 = d;
        8'hEE: m_c1 = d;
        8'hDA: m_io = d;
        8'hC4: m_fb = d;
        8'hE0: m_sb = d;
        8'hE2: begin
          if (d == 16'h1500) m_pw = 1;
          if (d == 16'hD200) m_pw = 0;
          if (d == 16'hDD00) m_ww = 1;
          if (d == 16'h3900) m_ww = 0;
          if (d == 16'h7E00) m_wr = 1;
          if (d == 16'h9400) m_wr = 0;
        end
        8'h90: begin
          if (d == 16'h3500) m_id = 1;
          else if (d == 16'h4900) m_id = 0;
        end
        default: ;
      endcase
      m_step = 0;
    end else if (a == key[m_step]) m_step++;
    else if (a == key[0]) m_step = 1;
    else m_step = 0;
  endfunction

  task automatic step(input logic v, input logic [23:0] a, input string tag);
    @(negedge clk);
    compare(last_tag);
    bus_valid = v;
    bus_addr  = a;
    model(v, a);
    last_tag = tag;
  endtask

  task automatic unlock(input string tag);
    for (int i = 0; i < 5; i++) step(1'b1, key[i], tag);
  endtask

  task automatic command(input logic [7:0] op, input logic [15:0] d, input string tag);
    unlock(tag);
    step(1'b1, {op, d}, tag);
    step(1'b0, 24'h0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    repeat (3) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;
    step(1'b0, 24'h0, "R1");

    // R3 R7 R11 R2: control word 0 with write enable and game select
    command(8'h37, 16'h2200, "R3");
    command(8'h37, 16'h0201, "R7");
    // R12: idle cycles with noisy address inside the key
    step(1'b1, key[0], "R12");
    step(1'b1, key[1], "R12");
    step(1'b0, 24'h123456, "R12");
    step(1'b0, key[0], "R12");
    step(1'b1, key[2], "R12");
    step(1'b1, key[3], "R12");
    step(1'b1, key[4], "R12");
    step(1'b0, 24'h37FFFF, "R12");
    step(1'b1, 24'hEE0630, "R11");
    step(1'b0, 24'h0, "R11");
    command(8'hEE, 16'h0631, "R11");
    command(8'hEE, 16'h0630, "R11");
    command(8'hDA, 16'hA5C3, "R7");
    command(8'hC4, 16'hFFFF, "R2");
    command(8'hE0, 16'h0042, "R7");

    // R4: broken key then command-like access ignored
    step(1'b1, key[0], "R4");
    step(1'b1, key[1], "R4");
    step(1'b1, 24'h02D200, "R4");
    step(1'b1, key[3], "R4");
    step(1'b1, key[4], "R4");
    step(1'b1, 24'h371234, "R4");
    step(1'b0, 24'h0, "R4");

    // R5: first step repeated mid-key restarts at step 2
    step(1'b1, key[0], "R5");
    step(1'b1, key[1], "R5");
    step(1'b1, key[0], "R5");
    for (int i = 1; i < 5; i++) step(1'b1, key[i], "R5");
    step(1'b1, 24'hDABEEF, "R5");
    step(1'b0, 24'h0, "R5");

    // R6: only one command per key
    unlock("R6");
    step(1'b1, 24'hC40011, "R6");
    step(1'b1, 24'hC40022, "R6");
    step(1'b1, 24'h37FFFF, "R6");
    step(1'b0, 24'h0, "R6");

    // R8: unknown command
    command(8'h55, 16'hFFFF, "R8");
    step(1'b1, 24'h37AAAA, "R8");

    // R9: ID mode
    command(8'h90, 16'h3500, "R9");
    command(8'h90, 16'h1234, "R9");
    command(8'h90, 16'h4900, "R9");
    command(8'h90, 16'h4901, "R9");

    // R10: options
    command(8'hE2, 16'h1500, "R10");
    command(8'hE2, 16'hDD00, "R10");
    command(8'hE2, 16'h7E00, "R10");
    command(8'hE2, 16'h0000, "R10");
    command(8'hE2, 16'hD200, "R10");
    command(8'hE2, 16'h3900, "R10");
    command(8'hE2, 16'h9400, "R10");

    // mixed stretch from key steps and command encodings
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 15);
      logic [23:0] a;
      logic [7:0] ops [8] = '{8'h37, 8'hEE, 8'hDA, 8'hC4, 8'hE0, 8'hE2, 8'h90, 8'h5A};
      logic [15:0] ds [8] = '{16'h1500, 16'hD200, 16'hDD00, 16'h3900, 16'h7E00, 16'h9400, 16'h3500, 16'h4900};
      if (r < 9) a = key[r % 5];
      else a = {ops[$urandom_range(0, 7)], ds[$urandom_range(0, 7)]};
      step($urandom_range(0, 4) != 0, a, "R3");
    end

    step(1'b0, 24'h0, "R6");
    @(negedge clk);
    compare(last_tag);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule